// File: doc/BRIEF.md
# Floating-Point Compare to Condition Code

This block compares two packed binary floating-point words, a left operand and a right operand. It reports the result as a four-bit processor condition code and as an invalid-operation flag. It is purely combinational, so the result is available in the same cycle as the operands. An integer pipeline or a status-flag writer can sample it at its own register boundary.

Two controls shape the result. The first makes quiet NaNs raise invalid, in the same way that signalling NaNs always do. The second replaces the right operand with positive zero, which gives a compare-against-zero form with no separate datapath. The exponent and fraction widths are parameters, and the default is single precision.

The ordering logic does not decode values arithmetically. Once NaNs and the pair of zeros have been taken aside, it orders the two words by their sign bits, then by their remaining bits read as an unsigned integer.

Top module: `fcmp_nzcv`

## Requirements
- R1: `nzcv` holds the flags N, Z, C, V in bits 3, 2, 1, 0. An equal result drives 4'b0110, a less-than result 4'b1000, a greater-than result 4'b0010 and an unordered result 4'b0011.
- R2: A word whose exponent field is all ones and whose fraction is nonzero is a NaN. If either operand is a NaN, the result is unordered.
- R3: `invalid` is 1 for a NaN operand whose fraction MSB is 0 (signalling), and for any NaN operand while `sig_quiet` is 1. With no NaN operand, `invalid` is 0.
- R4: Two identical words compare equal. Two words that are both zero compare equal, whatever their signs.
- R5: When the sign bits differ and the pair is not two zeros, the operand with sign bit 1 is the smaller.
- R6: When the sign bits match, the words below the sign bit are ordered as unsigned integers. The ordering is reversed when both signs are 1.
- R7: While `cmp_zero` is 1, the right operand is taken as all zeros, and `opd_m` has no effect on either output.
- R8: Infinities (exponent all ones, fraction zero) and denormals order like any other non-NaN value and never raise `invalid`.
- R9: Every input combination yields exactly one of the four codes listed in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_d | input | 1+EXP_W+FRAC_W | Left operand, packed sign/exponent/fraction |
| opd_m | input | 1+EXP_W+FRAC_W | Right operand, packed sign/exponent/fraction |
| cmp_zero | input | 1 | Replace the right operand with +0 |
| sig_quiet | input | 1 | Make quiet NaNs raise invalid as well |
| nzcv | output | 4 | Condition code {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The bench builds a main instance with a 3-bit exponent and a 2-bit fraction. That gives 64 codes per operand, covering both zeros, denormals, normals, both infinities, one signalling NaN and two quiet NaNs in each sign. Every pair of codes is applied under all four settings of `cmp_zero` and `sig_quiet`. Each result is compared with an ordering of real values that the bench decodes from the fields. A second instance at the default single-precision width receives directed operands. This shows that the wide exponent and fraction boundaries follow the same rules.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Condition codes {N,Z,C,V}
  localparam logic [3:0] CC_EQ = 4'b0110;
  localparam logic [3:0] CC_LT = 4'b1000;
  localparam logic [3:0] CC_GT = 4'b0010;
  localparam logic [3:0] CC_UN = 4'b0011;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } fcls_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] word,
  output fcls_t        cls
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              frac_nz;

  always_comb begin
    exp_f       = word[W-2:FRAC_W];
    frac_f      = word[FRAC_W-1:0];
    exp_ones    = &exp_f;
    frac_nz     = |frac_f;
    cls.sign    = word[W-1];
    cls.is_nan  = exp_ones & frac_nz;
    cls.is_snan = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
    cls.is_zero = ~(|word[W-2:0]);
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         raw_lt,
  output logic         raw_eq
);

  always_comb begin
    raw_lt = (a < b);
    raw_eq = (a == b);
  end

endmodule

// File: rtl/fcmp_resolve.sv
module fcmp_resolve
  import fcmp_pkg::*;
(
  input  fcls_t      cls_d,
  input  fcls_t      cls_m,
  input  logic       raw_lt,
  input  logic       raw_eq,
  input  logic       sig_quiet,
  output logic [3:0] nzcv,
  output logic       invalid
);

  logic unordered;
  logic both_zero;
  logic sign_split;

  always_comb begin
    unordered  = cls_d.is_nan | cls_m.is_nan;
    both_zero  = cls_d.is_zero & cls_m.is_zero;
    sign_split = cls_d.sign ^ cls_m.sign;
    invalid    = (cls_d.is_nan & (cls_d.is_snan | sig_quiet)) |
                 (cls_m.is_nan & (cls_m.is_snan | sig_quiet));
    if (unordered) begin
      nzcv = CC_UN;
    end else if (raw_eq || both_zero) begin
      nzcv = CC_EQ;
    end else if (sign_split) begin
      nzcv = cls_d.sign ? CC_LT : CC_GT;
    end else begin
      nzcv = (raw_lt ^ cls_d.sign) ? CC_LT : CC_GT;
    end
  end

endmodule

// File: rtl/fcmp_nzcv.sv
module fcmp_nzcv
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] opd_d,
  input  logic [W-1:0] opd_m,
  input  logic         cmp_zero,
  input  logic         sig_quiet,
  output logic [3:0]   nzcv,
  output logic         invalid
);

  localparam int NUM_OPS = 2;

  logic [W-1:0] ops [NUM_OPS];
  fcls_t        cls [NUM_OPS];
  logic         raw_lt;
  logic         raw_eq;

  always_comb begin
    ops[0] = opd_d;
    ops[1] = cmp_zero ? '0 : opd_m;
  end

  for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_cls
    fcmp_classify #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W)
    ) u_cls (
      .word(ops[gi]),
      .cls (cls[gi])
    );
  end

  fcmp_order #(
    .W(W - 1)
  ) u_order (
    .a     (ops[0][W-2:0]),
    .b     (ops[1][W-2:0]),
    .raw_lt(raw_lt),
    .raw_eq(raw_eq)
  );

  fcmp_resolve u_resolve (
    .cls_d    (cls[0]),
    .cls_m    (cls[1]),
    .raw_lt   (raw_lt),
    .raw_eq   (raw_eq & (ops[0][W-1] == ops[1][W-1])),
    .sig_quiet(sig_quiet),
    .nzcv     (nzcv),
    .invalid  (invalid)
  );

endmodule

// File: rtl/fcmp_nzcv_chk.sv
module fcmp_nzcv_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input logic [W-1:0] opd_d,
  input logic [W-1:0] opd_m,
  input logic         cmp_zero,
  input logic         sig_quiet,
  input logic [3:0]   nzcv,
  input logic         invalid
);

  logic [W-1:0] m_eff;
  logic         d_nan;
  logic         m_nan;
  logic         d_zero;
  logic         m_zero;
  logic         known;

  always_comb begin
    m_eff  = cmp_zero ? '0 : opd_m;
    d_nan  = (&opd_d[W-2:FRAC_W]) && (|opd_d[FRAC_W-1:0]);
    m_nan  = (&m_eff[W-2:FRAC_W]) && (|m_eff[FRAC_W-1:0]);
    d_zero = ~(|opd_d[W-2:0]);
    m_zero = ~(|m_eff[W-2:0]);
    known  = !$isunknown({opd_d, opd_m, cmp_zero, sig_quiet, nzcv, invalid});
    if (known) begin
      AST_ONE_CODE: assert (nzcv == 4'b0110 || nzcv == 4'b1000 ||
                            nzcv == 4'b0010 || nzcv == 4'b0011); // R9
      AST_NAN_UNORD: assert (!(d_nan || m_nan) || nzcv == 4'b0011); // R2
      AST_INV_NEEDS_NAN: assert (!invalid || (d_nan || m_nan)); // R3
      AST_QUIET_SIGNALS: assert (!(sig_quiet && (d_nan || m_nan)) || invalid); // R3
      AST_ZEROS_EQUAL: assert (!(d_zero && m_zero) || nzcv == 4'b0110); // R4
      AST_SAME_EQUAL: assert (d_nan || opd_d != m_eff || nzcv == 4'b0110); // R4
      AST_SIGN_SPLIT: assert (d_nan || m_nan || (d_zero && m_zero) ||
                              opd_d[W-1] == m_eff[W-1] ||
                              nzcv == (opd_d[W-1] ? 4'b1000 : 4'b0010)); // R5
    end
  end

endmodule

bind fcmp_nzcv fcmp_nzcv_chk #(
  .EXP_W (EXP_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .opd_d    (opd_d),
  .opd_m    (opd_m),
  .cmp_zero (cmp_zero),
  .sig_quiet(sig_quiet),
  .nzcv     (nzcv),
  .invalid  (invalid)
);

// File: tb/fcmp_nzcv_bench.sv
module fcmp_nzcv_bench;

  localparam int SE = 3;
  localparam int SF = 2;
  localparam int SW = 1 + SE + SF;
  localparam int NCODE = 1 << SW;
  localparam int BIAS = (1 << (SE - 1)) - 1;

  logic clk;
  logic rst_n;
  int   checks;
  int   errors;
  logic done;

  logic [SW-1:0] s_d, s_m;
  logic          s_cz, s_sq;
  logic [3:0]    s_cc;
  logic          s_inv;

  logic [31:0]   w_d, w_m;
  logic          w_cz, w_sq;
  logic [3:0]    w_cc;
  logic          w_inv;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  fcmp_nzcv #(.EXP_W(SE), .FRAC_W(SF)) u_fcmp_nzcv (
    .opd_d(s_d), .opd_m(s_m), .cmp_zero(s_cz), .sig_quiet(s_sq),
    .nzcv(s_cc), .invalid(s_inv)
  );

  fcmp_nzcv u_wide (
    .opd_d(w_d), .opd_m(w_m), .cmp_zero(w_cz), .sig_quiet(w_sq),
    .nzcv(w_cc), .invalid(w_inv)
  );

  function automatic logic is_nan_s(input logic [SW-1:0] x);
    return (x[SW-2:SF] == '1) && (x[SF-1:0] != '0);
  endfunction

  function automatic real val_s(input logic [SW-1:0] x);
    int  e;
    int  f;
    real mag;
    e = int'(x[SW-2:SF]);
    f = int'(x[SF-1:0]);
    if (e == (1 << SE) - 1) mag = 1.0e9;
    else if (e == 0) mag = (real'(f) / real'(1 << SF)) * (2.0 ** (1 - BIAS));
    else mag = (1.0 + real'(f) / real'(1 << SF)) * (2.0 ** (e - BIAS));
    return x[SW-1] ? -mag : mag;
  endfunction

  task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic wide(input logic [31:0] d, input logic [31:0] m, input logic cz,
                      input logic sq, input logic [3:0] ecc, input logic einv,
                      input string tag);
    @(posedge clk);
    w_d = d; w_m = m; w_cz = cz; w_sq = sq;
    @(negedge clk);
    check(tag, {w_cc, w_inv}, {ecc, einv});
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0;
    s_d = '0; s_m = '0; s_cz = 1'b0; s_sq = 1'b0;
    w_d = '0; w_m = '0; w_cz = 1'b0; w_sq = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // Exhaustive sweep over the small format
    for (int sq = 0; sq < 2; sq++) begin
      for (int cz = 0; cz < 2; cz++) begin
        for (int di = 0; di < NCODE; di++) begin
          for (int mi = 0; mi < NCODE; mi++) begin
            logic [SW-1:0] dv, mv, meff;
            logic [3:0] ecc;
            logic einv;
            real rd, rm;
            string tag;
            dv = SW'(di); mv = SW'(mi);
            meff = (cz != 0) ? '0 : mv;
            einv = 1'b0;
            if (is_nan_s(dv) && (!dv[SF-1] || sq != 0)) einv = 1'b1;
            if (is_nan_s(meff) && (!meff[SF-1] || sq != 0)) einv = 1'b1;
            rd = val_s(dv); rm = val_s(meff);
            if (is_nan_s(dv) || is_nan_s(meff)) begin
              ecc = 4'b0011; tag = "R2";
            end else begin
              if (rd == rm) ecc = 4'b0110;
              else if (rd < rm) ecc = 4'b1000;
              else ecc = 4'b0010;
              if (cz != 0) tag = "R7";
              else if (dv[SW-2:SF] == '1 || mv[SW-2:SF] == '1) tag = "R8";
              else if (rd == 0.0 && rm == 0.0) tag = "R4";
              else if (dv[SW-1] != mv[SW-1]) tag = "R5";
              else tag = "R6";
            end
            @(posedge clk);
            s_d = dv; s_m = mv; s_cz = 1'(cz); s_sq = 1'(sq);
            @(negedge clk);
            check({tag, " R1 flags"}, {s_cc, 1'b0}, {ecc, 1'b0});
            check("R3 invalid", {4'b0, s_inv}, {4'b0, einv});
          end
        end
      end
    end

    // Directed single-precision checks
    wide(32'h3F800000, 32'h40000000, 0, 0, 4'b1000, 0, "R6 1<2");
    wide(32'hBF800000, 32'hC0000000, 0, 0, 4'b0010, 0, "R6 -1>-2");
    wide(32'h00000000, 32'h80000000, 0, 0, 4'b0110, 0, "R4 +0==-0");
    wide(32'h7FC00000, 32'h3F800000, 0, 0, 4'b0011, 0, "R3 quiet no signal");
    wide(32'h7FC00000, 32'h3F800000, 0, 1, 4'b0011, 1, "R3 quiet signals");
    wide(32'h3F800000, 32'h7F800001, 0, 0, 4'b0011, 1, "R3 signalling");
    wide(32'h7F800000, 32'h7F7FFFFF, 0, 0, 4'b0010, 0, "R8 inf>max");
    wide(32'hFF800000, 32'h80000001, 0, 0, 4'b1000, 0, "R8 -inf<-denorm");
    wide(32'h80000001, 32'h7FC00000, 1, 1, 4'b1000, 0, "R7 m ignored");
    wide(32'h40490FDB, 32'hC0490FDB, 0, 0, 4'b0010, 0, "R5 split signs");
    wide(32'h40490FDB, 32'h40490FDB, 0, 0, 4'b0110, 0, "R4 identical");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule